// File: doc/BRIEF.md
# Multiphase Phase-Count Detect and Clock Distributor

This block sits between the master oscillator of a multiphase switching regulator and its per-phase PWM channels. It turns one master clock into up to four interleaved phase triggers. It also works out, by itself, how many phases the board actually fitted. When the controller is enabled, the block looks at two active-low strap flags for a short window. The flags report whether the two highest phase outputs are tied to ground. The block latches the resulting phase count and keeps it until the next enable. While running, it issues one trigger per master cycle, stepping through the active phases only. Each active phase therefore switches at the master frequency divided by the phase count.

Per-phase output-enable signals go with the triggers. An unused phase has its enable dropped, so its pin floats. A disabled controller drives every phase pin low. During the detect window the two strap-sensed pins are released so that the external sensing can see them.

Top module: `phase_clk_distributor`

## Requirements
- R1: While reset is asserted, or while `enable` is low, `phaseTrig` is 0, `phaseOe` is 4'b1111 (all pins driven low) and `activePhases` is 0.
- R2: During the first two master cycles after `enable` is first sampled high, `phaseTrig` is 0, `phaseOe` is 4'b0011 (the pins of phases 3 and 4 released) and `activePhases` is 0.
- R3: With neither strap flag low (`strapN` = 2'b11), `activePhases` becomes 4.
- R4: With only the fourth-phase flag low (`strapN[1]`=0, `strapN[0]`=1), `activePhases` becomes 3. With only the third-phase flag low (`strapN` = 2'b10), the flag is ignored and `activePhases` becomes 4.
- R5: With both flags low (`strapN` = 2'b00), `activePhases` becomes 2.
- R6: A change of `strapN` after the count is latched has no effect on `activePhases`, `phaseOe` or the rotation until the next enable.
- R7: In the third master cycle after enable, `phaseTrig[0]` pulses. In each following cycle the trigger moves to the next higher active phase and wraps from the last active phase back to phase 1. Each active phase is triggered once every N cycles, where N is `activePhases`.
- R8: While running, `phaseOe[i]` is 1 exactly for phases i < N. An inactive phase never carries a trigger.
- R9: At most one bit of `phaseTrig` is high in any cycle.
- R10: When `enable` is deasserted, in any state, the next cycle shows the R1 outputs. A new enable repeats the detect window and the latch.
- R11: The strap flags pass through a two-flop synchronizer. The count uses the `strapN` value present at the clock edge that first samples `enable` high. A change applied after that edge is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable, synchronous to clk |
| strapN | input | 2 | Active-low grounded flags: bit 0 for phase 3, bit 1 for phase 4 |
| phaseTrig | output | 4 | One-cycle trigger per phase, bit 0 is phase 1 |
| phaseOe | output | 4 | Per-phase pin drive enable; 0 means the pin floats |
| activePhases | output | 3 | Latched number of active phases, 0 when not running |

## Verification
The bench builds the block with its defaults: four phases, a two-stage synchronizer and a two-cycle detect window. With these values every strap combination and every phase count can be swept. For each of the four strap codes the bench computes the expected count and the trigger position arithmetically as one shifted by the cycle index modulo N, over several full rotations. It also moves the straps just after the enable edge, during a run and across an enable dropped inside the detect window. These cases exercise the latch timing and the ignore rules.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DETECT = 2'd1,
    ST_RUN    = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCount;   // enable low: forget latched count
    logic latchCount;   // last detect cycle: capture strap result
    logic detecting;    // detect window active
    logic running;      // rotation active
  } ctrlStrobes_t;

endpackage

// File: rtl/pcd_strap_sync.sv
module pcd_strap_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '1;
          else       stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '1;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/pcd_ctrl.sv
module pcd_ctrl
  import pcd_pkg::*;
#(
  parameter int DETECT_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  output ctrlStrobes_t strobes
);

  localparam int DET_W = $clog2(DETECT_CYCLES) + 1;
  localparam logic [DET_W-1:0] DET_LAST = DET_W'(DETECT_CYCLES - 1);

  ctrlState_t      stateQ, stateD;
  logic [DET_W-1:0] detCntQ, detCntD;

  always_comb begin
    stateD  = stateQ;
    detCntD = detCntQ;
    unique case (stateQ)
      ST_IDLE: begin
        detCntD = '0;
        if (enable) stateD = ST_DETECT;
      end
      ST_DETECT: begin
        if (!enable) begin
          stateD  = ST_IDLE;
          detCntD = '0;
        end else if (detCntQ == DET_LAST) begin
          stateD  = ST_RUN;
          detCntD = '0;
        end else begin
          detCntD = detCntQ + 1'b1;
        end
      end
      ST_RUN: begin
        detCntD = '0;
        if (!enable) stateD = ST_IDLE;
      end
      default: begin
        stateD  = ST_IDLE;
        detCntD = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      detCntQ <= '0;
    end else begin
      stateQ  <= stateD;
      detCntQ <= detCntD;
    end
  end

  always_comb begin
    strobes.clearCount = !enable;
    strobes.latchCount = (stateQ == ST_DETECT) && (detCntQ == DET_LAST) && enable;
    strobes.detecting  = (stateQ == ST_DETECT);
    strobes.running    = (stateQ == ST_RUN);
  end

  // R2: detect counter never passes the window length
  det_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    detCntQ <= DET_LAST);

  // R10: a low enable always returns control to idle on the next cycle
  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (stateQ == ST_IDLE));

  // R7: the run state is only entered from the last detect cycle
  // R7
  run_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stateQ == ST_RUN) |-> ($past(stateQ) == ST_DETECT) && ($past(detCntQ) == DET_LAST));

endmodule

// File: rtl/pcd_datapath.sv
module pcd_datapath
  import pcd_pkg::*;
#(
  parameter int MAX_PHASES = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobes_t                    strobes,
  input  logic [1:0]                      strapSyncN,
  output logic [MAX_PHASES-1:0]           phaseTrig,
  output logic [MAX_PHASES-1:0]           phaseOe,
  output logic [$clog2(MAX_PHASES+1)-1:0] activePhases
);

  localparam int SLOT_W = $clog2(MAX_PHASES);
  localparam int CNT_W  = $clog2(MAX_PHASES + 1);
  localparam int SENSED_FIRST = MAX_PHASES - 2;  // lowest strap-sensed phase index

  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  decodedCount;
  logic [SLOT_W-1:0] slotQ;
  logic [SLOT_W-1:0] slotLast;
  logic              topGround, nextGround;

  // decode strap flags: fourth-phase flag gates the third-phase flag
  always_comb begin
    topGround  = !strapSyncN[1];
    nextGround = !strapSyncN[0];
    if (topGround && nextGround)  decodedCount = CNT_W'(MAX_PHASES - 2);
    else if (topGround)           decodedCount = CNT_W'(MAX_PHASES - 1);
    else                          decodedCount = CNT_W'(MAX_PHASES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   countQ <= '0;
    else if (strobes.clearCount) countQ <= '0;
    else if (strobes.latchCount) countQ <= decodedCount;
  end

  assign slotLast = SLOT_W'(countQ - 1'b1);

  // rotating slot counter, modulo the latched count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   slotQ <= '0;
    else if (!strobes.running || strobes.clearCount) slotQ <= '0;
    else if (slotQ == slotLast)                  slotQ <= '0;
    else                                         slotQ <= slotQ + 1'b1;
  end

  generate
    for (genvar i = 0; i < MAX_PHASES; i++) begin : g_phase
      logic isActive;
      assign isActive     = (CNT_W'(i) < countQ);
      assign phaseTrig[i] = strobes.running && isActive && (slotQ == SLOT_W'(i));
      always_comb begin
        if (strobes.running)        phaseOe[i] = isActive;
        else if (strobes.detecting) phaseOe[i] = (i < SENSED_FIRST);
        else                        phaseOe[i] = 1'b1;
      end
    end
  endgenerate

  assign activePhases = countQ;

  // R9
  trig_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(phaseTrig));

  // R8
  trig_needs_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseTrig & ~phaseOe) == '0);

  // R2
  no_trig_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.running |-> (phaseTrig == '0));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.running && $past(strobes.running) && !strobes.clearCount |-> $stable(countQ));

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.running |-> (CNT_W'(slotQ) < countQ));

  // R1
  idle_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.running && !strobes.detecting |-> (countQ == '0));

endmodule

// File: rtl/phase_clk_distributor.sv
module phase_clk_distributor
  import pcd_pkg::*;
#(
  parameter int MAX_PHASES    = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int DETECT_CYCLES = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            enable,
  input  logic [1:0]                      strapN,
  output logic [MAX_PHASES-1:0]           phaseTrig,
  output logic [MAX_PHASES-1:0]           phaseOe,
  output logic [$clog2(MAX_PHASES+1)-1:0] activePhases
);

  ctrlStrobes_t strobes;
  logic [1:0]   strapSyncN;

  pcd_strap_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (strapN),
    .syncOut (strapSyncN)
  );

  pcd_ctrl #(
    .DETECT_CYCLES (DETECT_CYCLES)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .strobes (strobes)
  );

  pcd_datapath #(
    .MAX_PHASES (MAX_PHASES)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .strapSyncN   (strapSyncN),
    .phaseTrig    (phaseTrig),
    .phaseOe      (phaseOe),
    .activePhases (activePhases)
  );

endmodule

// File: tb/test_phase_clk_distributor.sv
module test_phase_clk_distributor;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] strapN = 2'b11;
  logic [3:0] phaseTrig;
  logic [3:0] phaseOe;
  logic [2:0] activePhases;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_clk_distributor i_phase_clk_distributor (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .strapN       (strapN),
    .phaseTrig    (phaseTrig),
    .phaseOe      (phaseOe),
    .activePhases (activePhases)
  );

  function automatic int expCount(logic [1:0] s);
    if (!s[1] && !s[0]) return 2;   // R5
    if (!s[1])          return 3;   // R4
    return 4;                        // R3, R4 third-only ignored
  endfunction

  function automatic string countTag(int n);
    if (n == 2) return "R5";
    if (n == 3) return "R4";
    return "R3";
  endfunction

  task automatic checkOut(string tag, logic [3:0] eTrig, logic [3:0] eOe, logic [2:0] eCnt);
    checks++;
    if (phaseTrig !== eTrig || phaseOe !== eOe || activePhases !== eCnt) begin
      errors++;
      $display("FAIL %s: trig=%b oe=%b cnt=%0d expected trig=%b oe=%b cnt=%0d",
               tag, phaseTrig, phaseOe, activePhases, eTrig, eOe, eCnt);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // one enable session; samples taken at negedge, inputs changed after the check
  task automatic runCase(logic [1:0] strap, bit lateFlip, bit midFlip, int rotations);
    int n;
    logic [3:0] mask;
    strapN = strap;
    repeat (3) step();
    checkOut("R1 idle", 4'b0000, 4'b1111, 3'd0);
    enable = 1'b1;
    step();
    checkOut("R2 detect cycle 1", 4'b0000, 4'b0011, 3'd0);
    if (lateFlip) strapN = ~strap;   // R11: after the enable edge, must be ignored
    step();
    checkOut("R2 detect cycle 2", 4'b0000, 4'b0011, 3'd0);
    step();
    n = expCount(strap);
    mask = 4'((1 << n) - 1);
    for (int k = 0; k < rotations * n; k++) begin
      string tag;
      if (k == 0)      tag = {countTag(n), " R7 first trigger"};
      else if (lateFlip) tag = "R11 R7 R8 R9 rotation";
      else if (midFlip)  tag = "R6 R7 R8 R9 rotation";
      else             tag = "R7 R8 R9 rotation";
      checkOut(tag, 4'(1 << (k % n)), mask, 3'(n));
      if (midFlip && k == 2) strapN = ~strapN;   // R6
      step();
    end
    enable = 1'b0;
    step();
    checkOut("R10 disable", 4'b0000, 4'b1111, 3'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    step();
    checkOut("R1 reset", 4'b0000, 4'b1111, 3'd0);
    enable = 1'b1;   // enable held during reset must have no effect
    step();
    checkOut("R1 reset with enable", 4'b0000, 4'b1111, 3'd0);
    enable = 1'b0;
    step();
    rstN = 1'b1;
    step();
    checkOut("R1 after reset", 4'b0000, 4'b1111, 3'd0);

    // sweep all strap codes
    for (int s = 0; s < 4; s++) runCase(2'(s), 1'b0, 1'b0, 3);
    // late strap changes around the enable edge
    for (int s = 0; s < 4; s++) runCase(2'(s), 1'b1, 1'b0, 2);
    // strap changes while running
    for (int s = 0; s < 4; s++) runCase(2'(s), 1'b0, 1'b1, 3);

    // R10: enable dropped inside detect window, then re-detect
    strapN = 2'b01;
    repeat (3) step();
    enable = 1'b1;
    step();
    checkOut("R10 R2 detect before abort", 4'b0000, 4'b0011, 3'd0);
    enable = 1'b0;
    step();
    checkOut("R10 abort in detect", 4'b0000, 4'b1111, 3'd0);
    step();
    checkOut("R10 stays idle", 4'b0000, 4'b1111, 3'd0);
    runCase(2'b00, 1'b0, 1'b0, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule